// File: doc/BRIEF.md
# Clock Ratio Supervisor and Start-up Sequencer

This block sits beside an audio converter's digital path. It runs on a free-running reference clock and watches two inputs that are already synchronized into that domain: a master clock and a frame clock. It counts master clock rising edges between frame rising edges and classifies the ratio into one of three speed modes. A new mode is accepted only when two frames in a row measure the same legal ratio.

When a ratio is accepted, the block starts its output path in stages. The digital section is enabled a fixed number of frames later. Output data is then still held at zero for a settling count that depends on the mode. The block drops back to reset in four cases: the master clock stops, the frame clock stops for too long, a frame measures an illegal ratio, or a different mode is confirmed. In the last case the start-up sequence runs again. A flag tells the data path whether the de-emphasis filter may run.

All pins are plain control and status levels. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `dac_clock_supervisor`

## Requirements
- R1: While reset is asserted and right after it is released, `dig_enable`, `out_valid` and `deemph_allow` are 0 and `speed_mode` is 2'b00.
- R2: A confirmed ratio of 512, 768 or 1152 master clock rising edges per frame gives `speed_mode` = 2'b00 (normal).
- R3: A confirmed ratio of 256 or 384 gives `speed_mode` = 2'b01 (double).
- R4: A confirmed ratio of 128 or 192 gives `speed_mode` = 2'b10 (quad).
- R5: The first frame rising edge after start only marks a start point. A ratio is confirmed at the frame rising edge whose measurement equals the one before it. While running, a single frame that measures a different legal ratio changes nothing.
- R6: A frame whose count matches no legal ratio clears `dig_enable` and `out_valid`. They stay clear until a new ratio is confirmed.
- R7: If more than LOSS_FRAMES times the locked ratio of master clock rising edges pass with no frame rising edge, the block returns to reset. It starts up again once frames resume.
- R8: If MCLK_TO reference cycles pass with no master clock rising edge, the block returns to reset. A shorter gap has no effect.
- R9: `dig_enable` rises at the DIG_FRAMES-th frame rising edge after the confirming edge (the 5th rising edge of a fresh run when DIG_FRAMES is 2).
- R10: `out_valid` rises S frame rising edges after `dig_enable`, where S is SETTLE_BASE/16 in normal, SETTLE_BASE/8 in double and SETTLE_BASE/4 in quad mode.
- R11: `deemph_allow` is 1 only while `dig_enable` is 1 and `speed_mode` is 2'b00.
- R12: When a ratio of a different speed mode is confirmed, `speed_mode` takes the new value and the staged start-up runs again from the confirming edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclk_sync | input | 1 | Master clock level, synchronized to clk |
| fclk_sync | input | 1 | Frame clock level, synchronized to clk |
| speed_mode | output | 2 | 00 normal, 01 double, 10 quad |
| dig_enable | output | 1 | Digital section enabled |
| out_valid | output | 1 | Output data may pass; when 0 the output is forced to zero |
| deemph_allow | output | 1 | De-emphasis filter may run |

## Verification
The assertions check on every cycle that any of these drops `dig_enable` by the next cycle: master clock loss, frame loss, or an illegal measurement. They also check that `dig_enable` and `out_valid` rise only on the cycle after a frame measurement, and that `speed_mode` does not change while the digital section is enabled. Some behaviour only the bench scenarios can show: the exact frame on which each stage turns on for each ratio, the confirmation of a mode change, the edges of both loss timeouts, and a clean restart after each kind of fault.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_e;

  typedef enum logic [1:0] {
    ST_RESET,
    ST_DIGWAIT,
    ST_SETTLE,
    ST_RUN
  } seq_state_e;

  typedef struct packed {
    logic   legal;
    speed_e mode;
  } ratio_class_t;

  localparam int unsigned MAX_RATIO = 1152;

  function automatic ratio_class_t classify_ratio(input logic [31:0] r);
    ratio_class_t c;
    c.legal = 1'b1;
    c.mode  = SPD_NORMAL;
    case (r)
      32'd512, 32'd768, 32'd1152: c.mode = SPD_NORMAL;
      32'd256, 32'd384:           c.mode = SPD_DOUBLE;
      32'd128, 32'd192:           c.mode = SPD_QUAD;
      default:                    c.legal = 1'b0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/dcs_clk_monitor.sv
module dcs_clk_monitor #(
  parameter int unsigned MCLK_TO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_sync,
  input  logic fclk_sync,
  output logic mclk_rise,
  output logic frame_rise,
  output logic mclk_lost
);
  localparam int unsigned TO_W = $clog2(MCLK_TO + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(MCLK_TO - 1);

  logic            mclk_d, fclk_d;
  logic [TO_W-1:0] idle;

  assign mclk_rise  = mclk_sync & ~mclk_d;
  assign frame_rise = fclk_sync & ~fclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk_d    <= 1'b0;
      fclk_d    <= 1'b0;
      idle      <= '0;
      mclk_lost <= 1'b1;
    end else begin
      mclk_d <= mclk_sync;
      fclk_d <= fclk_sync;
      if (mclk_rise) begin
        idle      <= '0;
        mclk_lost <= 1'b0;
      end else if (idle == TO_LAST) begin
        mclk_lost <= 1'b1;
      end else begin
        idle <= idle + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcs_ratio_meter.sv
module dcs_ratio_meter
  import dcs_pkg::*;
#(
  parameter int unsigned LOSS_FRAMES = 2048
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   mclk_rise,
  input  logic   frame_rise,
  output logic   evt_o,
  output logic   legal_o,
  output logic   conf_o,
  output speed_e mode_o,
  output logic   frame_lost
);
  localparam int unsigned CNT_W   = $clog2(LOSS_FRAMES * MAX_RATIO + 2);
  localparam int unsigned RATIO_W = $clog2(MAX_RATIO + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LOSS_K  = CNT_W'(LOSS_FRAMES);

  logic [CNT_W-1:0]   cnt, cnt_inc, hist, loss_lim;
  logic [RATIO_W-1:0] lock_ratio;
  logic               started, hist_valid, match;
  ratio_class_t       cls;

  always_comb begin
    if (cnt == CNT_MAX) cnt_inc = cnt;
    else                cnt_inc = cnt + CNT_W'(mclk_rise);
  end

  assign cls        = classify_ratio(32'(cnt_inc));
  assign match      = cls.legal && hist_valid && (hist == cnt_inc);
  assign loss_lim   = LOSS_K * CNT_W'(lock_ratio);
  assign frame_lost = cnt > loss_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      hist       <= '0;
      hist_valid <= 1'b0;
      started    <= 1'b0;
      lock_ratio <= '0;
      evt_o      <= 1'b0;
      legal_o    <= 1'b0;
      conf_o     <= 1'b0;
      mode_o     <= SPD_NORMAL;
    end else if (clr && !mclk_rise) begin
      cnt        <= '0;
      hist_valid <= 1'b0;
      started    <= 1'b0;
      evt_o      <= 1'b0;
    end else begin
      evt_o <= frame_rise && started;
      if (frame_rise) begin
        cnt     <= '0;
        started <= 1'b1;
        if (started) begin
          legal_o    <= cls.legal;
          mode_o     <= cls.mode;
          conf_o     <= match;
          hist       <= cnt_inc;
          hist_valid <= cls.legal;
          if (match) lock_ratio <= RATIO_W'(cnt_inc);
        end
      end else begin
        cnt <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/dcs_sequencer.sv
module dcs_sequencer
  import dcs_pkg::*;
#(
  parameter int unsigned SETTLE_BASE = 1024,
  parameter int unsigned DIG_FRAMES  = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mclk_lost,
  input  logic   frame_lost,
  input  logic   evt,
  input  logic   legal,
  input  logic   conf,
  input  speed_e mode_in,
  output speed_e speed,
  output logic   dig_en,
  output logic   out_valid,
  output logic   deemph_ok
);
  localparam int unsigned FC_W = $clog2(SETTLE_BASE / 4 + DIG_FRAMES + 1);
  localparam logic [FC_W-1:0] DIG_LAST = FC_W'(DIG_FRAMES - 1);

  seq_state_e      state;
  logic [FC_W-1:0] fc, settle_last;

  always_comb begin
    case (speed)
      SPD_NORMAL: settle_last = FC_W'(SETTLE_BASE / 16) - FC_W'(1);
      SPD_DOUBLE: settle_last = FC_W'(SETTLE_BASE / 8) - FC_W'(1);
      default:    settle_last = FC_W'(SETTLE_BASE / 4) - FC_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RESET;
      fc    <= '0;
      speed <= SPD_NORMAL;
    end else if (mclk_lost || frame_lost) begin
      state <= ST_RESET;
      fc    <= '0;
    end else if (evt) begin
      if (!legal) begin
        state <= ST_RESET;
        fc    <= '0;
      end else if (conf && (state == ST_RESET || mode_in != speed)) begin
        speed <= mode_in;
        state <= ST_DIGWAIT;
        fc    <= '0;
      end else begin
        case (state)
          ST_DIGWAIT: begin
            if (fc == DIG_LAST) begin
              state <= ST_SETTLE;
              fc    <= '0;
            end else fc <= fc + 1'b1;
          end
          ST_SETTLE: begin
            if (fc == settle_last) begin
              state <= ST_RUN;
              fc    <= '0;
            end else fc <= fc + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign dig_en    = (state == ST_SETTLE) || (state == ST_RUN);
  assign out_valid = (state == ST_RUN);
  assign deemph_ok = dig_en && (speed == SPD_NORMAL);

  p_mclk_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_lost |=> !dig_en);
  p_frame_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lost |=> !dig_en);
  p_illegal_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !legal) |=> !dig_en);
  p_dig_on_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dig_en) |-> $past(evt));
  p_valid_on_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(evt));
  p_mode_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_en && $past(dig_en)) |-> $stable(speed));
endmodule

// File: rtl/dac_clock_supervisor.sv
module dac_clock_supervisor
  import dcs_pkg::*;
#(
  parameter int unsigned MCLK_TO     = 64,
  parameter int unsigned LOSS_FRAMES = 2048,
  parameter int unsigned SETTLE_BASE = 1024,
  parameter int unsigned DIG_FRAMES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclk_sync,
  input  logic       fclk_sync,
  output logic [1:0] speed_mode,
  output logic       dig_enable,
  output logic       out_valid,
  output logic       deemph_allow
);
  logic   mclk_rise, frame_rise, mclk_lost, frame_lost;
  logic   evt, legal, conf;
  speed_e meas_mode, speed;

  dcs_clk_monitor #(.MCLK_TO(MCLK_TO)) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .mclk_sync  (mclk_sync),
    .fclk_sync  (fclk_sync),
    .mclk_rise  (mclk_rise),
    .frame_rise (frame_rise),
    .mclk_lost  (mclk_lost)
  );

  dcs_ratio_meter #(.LOSS_FRAMES(LOSS_FRAMES)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (mclk_lost),
    .mclk_rise  (mclk_rise),
    .frame_rise (frame_rise),
    .evt_o      (evt),
    .legal_o    (legal),
    .conf_o     (conf),
    .mode_o     (meas_mode),
    .frame_lost (frame_lost)
  );

  dcs_sequencer #(.SETTLE_BASE(SETTLE_BASE), .DIG_FRAMES(DIG_FRAMES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mclk_lost  (mclk_lost),
    .frame_lost (frame_lost),
    .evt        (evt),
    .legal      (legal),
    .conf       (conf),
    .mode_in    (meas_mode),
    .speed      (speed),
    .dig_en     (dig_enable),
    .out_valid  (out_valid),
    .deemph_ok  (deemph_allow)
  );

  assign speed_mode = speed;
endmodule

// File: tb/dac_clock_supervisor_bench.sv
`timescale 1ns/1ps
module dac_clock_supervisor_bench;
  localparam int LOSS = 4;
  localparam int SB   = 64;

  logic clk = 1'b0;
  logic rst_n, mclk, fclk;
  logic [1:0] speed_mode;
  logic dig_enable, out_valid, deemph_allow;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_clock_supervisor #(.MCLK_TO(64), .LOSS_FRAMES(LOSS), .SETTLE_BASE(SB), .DIG_FRAMES(2))
  u_dac_clock_supervisor (
    .clk(clk), .rst_n(rst_n), .mclk_sync(mclk), .fclk_sync(fclk),
    .speed_mode(speed_mode), .dig_enable(dig_enable),
    .out_valid(out_valid), .deemph_allow(deemph_allow)
  );

  function automatic int mode_of(input int r);
    if (r >= 512) return 0;
    if (r >= 256) return 1;
    return 2;
  endfunction

  function automatic int settle(input int r);
    if (r >= 512) return SB / 16;
    if (r >= 256) return SB / 8;
    return SB / 4;
  endfunction

  function automatic string mode_tag(input int r);
    if (r >= 512) return "R2";
    if (r >= 256) return "R3";
    return "R4";
  endfunction

  function automatic int pick(input int k);
    case (k)
      0: return 128;
      1: return 192;
      2: return 256;
      3: return 384;
      4: return 512;
      5: return 768;
      default: return 1152;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mtick(input bit f);
    @(negedge clk);
    mclk = 1'b1;
    fclk = f;
    @(negedge clk);
    mclk = 1'b0;
  endtask

  // Frames of ratio r; idx counts frame rising edges in this run.
  task automatic lock_run(input int r, input int n, input bit carry, input int old_mode);
    int s;
    s = settle(r);
    for (int idx = 1; idx <= n; idx++) begin
      for (int i = 0; i < r; i++) begin
        mtick(i < r / 2);
        if (i == r / 2) begin
          int e_dig, e_ov, e_mode;
          bit mode_known;
          string dtag;
          if (carry && idx <= 2) begin
            e_dig = 1; e_ov = 1; e_mode = old_mode; mode_known = 1; dtag = "R5";
          end else begin
            e_dig = (idx >= 5) ? 1 : 0;
            e_ov  = (idx >= 5 + s) ? 1 : 0;
            mode_known = (idx >= 3) || carry;
            e_mode = (idx >= 3) ? mode_of(r) : old_mode;
            dtag = carry ? "R12" : ((idx <= 3) ? "R5" : "R9");
          end
          check(dig_enable == e_dig[0], dtag, int'(dig_enable), e_dig);
          check(out_valid == e_ov[0], "R10", int'(out_valid), e_ov);
          if (mode_known)
            check(int'(speed_mode) == e_mode, (carry && idx <= 2) ? "R5" : mode_tag(r),
                  int'(speed_mode), e_mode);
          if (mode_known || e_dig == 0)
            check(deemph_allow == (e_dig == 1 && e_mode == 0), "R11",
                  int'(deemph_allow), (e_dig == 1 && e_mode == 0) ? 1 : 0);
        end
      end
    end
  endtask

  task automatic illegal_run(input int rb, input int n);
    for (int idx = 1; idx <= n; idx++) begin
      for (int i = 0; i < rb; i++) begin
        mtick(i < rb / 2);
        if (i == rb / 2) begin
          int e;
          e = (idx == 1) ? 1 : 0;
          check(dig_enable == e[0], "R6", int'(dig_enable), e);
          if (idx > 1) check(out_valid == 1'b0, "R6", int'(out_valid), 0);
        end
      end
    end
  endtask

  task automatic frame_loss(input int rp);
    for (int k = 0; k < LOSS * rp - rp; k++) mtick(1'b0);
    check(dig_enable == 1'b1, "R7", int'(dig_enable), 1);
    for (int k = 0; k < 2 * rp; k++) mtick(1'b0);
    check(dig_enable == 1'b0, "R7", int'(dig_enable), 0);
    check(out_valid == 1'b0, "R7", int'(out_valid), 0);
  endtask

  task automatic mclk_loss();
    repeat (40) @(negedge clk);
    check(dig_enable == 1'b1, "R8", int'(dig_enable), 1);
    repeat (80) @(negedge clk);
    check(dig_enable == 1'b0, "R8", int'(dig_enable), 0);
    check(out_valid == 1'b0, "R8", int'(out_valid), 0);
  endtask

  initial begin
    int unsigned seed_init;
    int r_prev;
    seed_init = $urandom(32'd20240611);
    rst_n = 1'b0;
    mclk = 1'b0;
    fclk = 1'b0;
    repeat (5) @(negedge clk);
    check(dig_enable == 1'b0, "R1", int'(dig_enable), 0);
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(deemph_allow == 1'b0, "R1", int'(deemph_allow), 0);
    check(speed_mode == 2'b00, "R1", int'(speed_mode), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(dig_enable == 1'b0, "R1", int'(dig_enable), 0);

    lock_run(768, 11, 1'b0, 0);          // normal mode, fresh start
    lock_run(128, 23, 1'b1, 0);          // R12: switch to quad
    illegal_run(600, 4);                 // R6 from running
    lock_run(384, 15, 1'b0, 2);          // double mode after illegal frames
    r_prev = 384;

    for (int it = 0; it < 3; it++) begin
      int r;
      r = pick(int'($urandom % 7));
      case (it)
        0: frame_loss(r_prev);
        1: mclk_loss();
        default: illegal_run(600 + 2 * int'($urandom % 40), 3);
      endcase
      lock_run(r, 6 + settle(r), 1'b0, mode_of(r_prev));
      r_prev = r;
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule